// File: doc/BRIEF.md
# Clocked Synchronous Serial Port

The block moves one frame of 1 to 8 bits over a clock-synchronous serial link. It has a serial data output, a serial data input and a shift clock that it either drives, as master, or receives, as slave. Software-side logic loads a data register, pulses a start strobe and waits for a one-cycle completion pulse. The received bits then sit right-aligned in a receive register. The frame length, the bit order and the clock edge used for each direction are set by configuration inputs. A two-wire transmit-only mode ignores the data input.

As master, the shift clock comes from one of eight sources: the block clock divided by one of four ratios, a slower system tick divided by one of two ratios, a timer tick, or an external tick. Between frames the clock rests at a defined level. A second frame can be queued while one is running, and it then follows with no idle clock period between the two frames.

Top module: `sync_serial_port`

## Requirements
- R1: The frame length is `cfg_len_m1 + 1` bits (1 to 8). After a frame, `rx_data` holds the received bits right-aligned, and every bit above the frame length is zero.
- R2: With `cfg_lsb_first` = 1, bit 0 of the data register is sent first and bit 0 of `rx_data` is the first bit received. With `cfg_lsb_first` = 0, bit `len-1` is sent first and the first bit received ends up in bit `len-1`.
- R3: As master, `sck_o` rests high when `cfg_out_rise` = 1 and low when it is 0. `sdo` moves only on rising edges of the shift clock when `cfg_out_rise` = 1, and only on falling edges otherwise. `sdi` is sampled on rising edges when `cfg_smp_rise` = 1, and on falling edges otherwise. A frame spans exactly 2·len clock edges and ends at the resting level.
- R4: With `cfg_two_wire` = 1, `sdi` is ignored and the frame's `rx_data` is all zeros.
- R5: `cfg_src` selects the master half-period as follows. 0, 1, 2 and 3 give 1, 2, 8 and 32 `clk` cycles. 4 and 5 give 1 and 2 `sys_tick` pulses. 6 gives one `tmr_tick` pulse. 7 gives one `ext_tick` pulse.
- R6: `done_irq` is high for exactly one cycle per completed frame. `busy` never falls without `done_irq` being high in the same cycle.
- R7: `busy` rises on the cycle after `start` and stays high until the frame's last edge. `data_we` and `start` have no effect while `busy` is high.
- R8: While `busy` is high and no frame is pending, `queue_we` stores `queue_data`. When the current frame ends, that frame starts at once with the same configuration, `busy` stays high, and the clock keeps its half-period with no gap.
- R9: As slave (`cfg_master` = 0), `sck_oe` is low and the shift clock is taken from `sck_i` through a two-stage synchronizer. A frame ends on its len-th sample edge. The external clock must rest at the level that its output edge leaves.
- R10: While `busy` is low, `sdo` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_master | input | 1 | 1 = drive the shift clock, 0 = follow `sck_i` |
| cfg_two_wire | input | 1 | 1 = transmit-only, ignore `sdi` |
| cfg_lsb_first | input | 1 | Bit order select |
| cfg_out_rise | input | 1 | Output edge: 1 rising, 0 falling |
| cfg_smp_rise | input | 1 | Sample edge: 1 rising, 0 falling |
| cfg_len_m1 | input | 3 | Frame length minus one |
| cfg_src | input | 3 | Master clock source select |
| sys_tick | input | 1 | System clock enable pulse |
| tmr_tick | input | 1 | Timer output pulse |
| ext_tick | input | 1 | External clock pulse |
| data_we | input | 1 | Write strobe for the data register |
| data_in | input | 8 | Data register write value |
| start | input | 1 | Start a frame |
| queue_we | input | 1 | Queue a follow-on frame |
| queue_data | input | 8 | Data for the queued frame |
| busy | output | 1 | Frame in progress |
| rx_data | output | 8 | Received frame, right-aligned |
| done_irq | output | 1 | One-cycle completion pulse |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |
| sck_o | output | 1 | Shift clock driven as master |
| sck_oe | output | 1 | Shift clock output enable |
| sck_i | input | 1 | Shift clock received as slave |

## Verification
The hardest point to reach is the frame boundary of a queued transfer. There, the completion pulse, the reload of the shifter and the next clock edge fall in the same few cycles, and a gap of a single idle half-period is visible only in the clock timing. The bench queues a frame during a running one and measures the largest interval between shift-clock toggles across both frames. To check the bit order independently of loopback, the bench records `sdo` just before every sample edge. It sweeps every length, both orders and all four edge pairings, then repeats length and order as slave with its own bit-serial clock.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
   typedef enum logic [2:0] {
      SRC_CLK_A = 3'd0,
      SRC_CLK_B = 3'd1,
      SRC_CLK_C = 3'd2,
      SRC_CLK_D = 3'd3,
      SRC_SYS_A = 3'd4,
      SRC_SYS_B = 3'd5,
      SRC_TMR   = 3'd6,
      SRC_EXT   = 3'd7
   } clk_src_e;

   function automatic int unsigned max_of(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction
endpackage

// File: rtl/ssp_clkgen.sv
module ssp_clkgen import ssp_pkg::*; #(
   parameter int unsigned DIV_A = 2,
   parameter int unsigned DIV_B = 4,
   parameter int unsigned DIV_C = 16,
   parameter int unsigned DIV_D = 64,
   parameter int unsigned SDIV_A = 2,
   parameter int unsigned SDIV_B = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       run,
   input  logic [2:0] src,
   input  logic       sys_tick,
   input  logic       tmr_tick,
   input  logic       ext_tick,
   output logic       half_tick
);
   localparam int unsigned MAXDIV = max_of(max_of(max_of(DIV_A, DIV_B), max_of(DIV_C, DIV_D)),
                                           max_of(SDIV_A, SDIV_B));
   localparam int unsigned CW = $clog2(MAXDIV / 2 + 1);

   generate
      if ((DIV_A % 2) != 0 || (DIV_B % 2) != 0 || (DIV_C % 2) != 0 || (DIV_D % 2) != 0 ||
          (SDIV_A % 2) != 0 || (SDIV_B % 2) != 0 || DIV_A < 2 || SDIV_A < 2)
         $error("ssp_clkgen: every divide ratio must be even and at least 2");
   endgenerate

   logic [CW-1:0] cnt_q;
   logic [CW-1:0] term;
   logic          step;

   always_comb begin
      step = 1'b1;
      term = '0;
      unique case (clk_src_e'(src))
         SRC_CLK_A: term = CW'(DIV_A / 2 - 1);
         SRC_CLK_B: term = CW'(DIV_B / 2 - 1);
         SRC_CLK_C: term = CW'(DIV_C / 2 - 1);
         SRC_CLK_D: term = CW'(DIV_D / 2 - 1);
         SRC_SYS_A: begin step = sys_tick; term = CW'(SDIV_A / 2 - 1); end
         SRC_SYS_B: begin step = sys_tick; term = CW'(SDIV_B / 2 - 1); end
         SRC_TMR:   step = tmr_tick;
         SRC_EXT:   step = ext_tick;
         default:   step = 1'b0;
      endcase
   end

   assign half_tick = run & step & (cnt_q == term);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         cnt_q <= '0;
      else if (!run)      cnt_q <= '0;
      else if (half_tick) cnt_q <= '0;
      else if (step)      cnt_q <= cnt_q + CW'(1);
   end
endmodule

// File: rtl/ssp_sync.sv
module ssp_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sck_i,
   input  logic sdi,
   output logic rise,
   output logic fall,
   output logic sdi_s
);
   generate
      if (STAGES < 2) $error("ssp_sync: at least two stages are needed");
   endgenerate

   logic [STAGES-1:0] sck_sr;
   logic [STAGES-1:0] dat_sr;
   logic              sck_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_sr <= '0;
         dat_sr <= '0;
         sck_d  <= 1'b0;
      end else begin
         sck_sr <= {sck_sr[STAGES-2:0], sck_i};
         dat_sr <= {dat_sr[STAGES-2:0], sdi};
         sck_d  <= sck_sr[STAGES-1];
      end
   end

   assign rise  =  sck_sr[STAGES-1] & ~sck_d;
   assign fall  = ~sck_sr[STAGES-1] &  sck_d;
   assign sdi_s =  dat_sr[STAGES-1];
endmodule

// File: rtl/ssp_shifter.sv
module ssp_shifter #(
   parameter int unsigned DW = 8,
   localparam int unsigned LW = $clog2(DW)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cfg_master,
   input  logic          cfg_two_wire,
   input  logic          cfg_lsb_first,
   input  logic          cfg_out_rise,
   input  logic          cfg_smp_rise,
   input  logic [LW-1:0] cfg_len_m1,
   input  logic          data_we,
   input  logic [DW-1:0] data_in,
   input  logic          start,
   input  logic          queue_we,
   input  logic [DW-1:0] queue_data,
   input  logic          half_tick,
   input  logic          s_rise,
   input  logic          s_fall,
   input  logic          sdi_m,
   input  logic          sdi_s,
   output logic          busy,
   output logic          master_run,
   output logic [DW-1:0] rx_data,
   output logic          done_irq,
   output logic          sdo,
   output logic          sck_o
);
   logic          busy_q, lsb_q, oe_q, se_q, two_q, mst_q;
   logic [LW-1:0] lenm1_q;
   logic [DW-1:0] data_q, pend_d, tx_q, rx_q, rxd_q;
   logic          pend_q, sdo_q, sck_q, irq_q;
   logic [LW:0]   smp_cnt;
   logic [LW+1:0] edge_cnt;

   logic          ev, is_rise, smp_ev, out_ev, bit_in, fin, launch;
   logic [LW:0]   len_full, smp_nxt, sh_amt;
   logic [DW-1:0] rx_nxt, rx_al, tx_sh;

   function automatic logic first_bit(input logic [DW-1:0] d, input logic lsb,
                                      input logic [LW-1:0] lm1);
      return lsb ? d[0] : d[lm1];
   endfunction

   always_comb begin
      ev       = busy_q & (mst_q ? half_tick : (s_rise | s_fall));
      is_rise  = mst_q ? ~sck_q : s_rise;
      smp_ev   = ev & (is_rise == se_q);
      out_ev   = ev & (is_rise == oe_q);
      bit_in   = two_q ? 1'b0 : (mst_q ? sdi_m : sdi_s);
      len_full = {1'b0, lenm1_q} + (LW+1)'(1);
      smp_nxt  = smp_cnt + {{LW{1'b0}}, smp_ev};
      fin      = mst_q ? (ev && (edge_cnt == ({len_full, 1'b0} - (LW+2)'(1))))
                       : (smp_ev && (smp_nxt == len_full));
      if (smp_ev) rx_nxt = lsb_q ? {bit_in, rx_q[DW-1:1]} : {rx_q[DW-2:0], bit_in};
      else        rx_nxt = rx_q;
      sh_amt   = (LW+1)'(DW) - len_full;
      rx_al    = lsb_q ? (rx_nxt >> sh_amt) : rx_nxt;
      tx_sh    = lsb_q ? (tx_q >> 1) : (tx_q << 1);
      launch   = start & ~busy_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0; lsb_q <= 1'b0; oe_q <= 1'b0; se_q <= 1'b0;
         two_q <= 1'b0; mst_q <= 1'b0; lenm1_q <= '0;
         data_q <= '0; pend_d <= '0; tx_q <= '0; rx_q <= '0; rxd_q <= '0;
         pend_q <= 1'b0; sdo_q <= 1'b0; sck_q <= 1'b0; irq_q <= 1'b0;
         smp_cnt <= '0; edge_cnt <= '0;
      end else begin
         irq_q <= 1'b0;
         if (data_we && !busy_q) data_q <= data_in;
         if (queue_we && busy_q && !pend_q && !fin) begin
            pend_q <= 1'b1;
            pend_d <= queue_data;
         end
         if (!busy_q)            sck_q <= cfg_out_rise;
         else if (mst_q && ev)   sck_q <= ~sck_q;

         if (launch) begin
            busy_q   <= 1'b1;
            lsb_q    <= cfg_lsb_first;
            oe_q     <= cfg_out_rise;
            se_q     <= cfg_smp_rise;
            two_q    <= cfg_two_wire;
            mst_q    <= cfg_master;
            lenm1_q  <= cfg_len_m1;
            tx_q     <= data_q;
            sdo_q    <= first_bit(data_q, cfg_lsb_first, cfg_len_m1);
            rx_q     <= '0;
            smp_cnt  <= '0;
            edge_cnt <= '0;
         end else if (busy_q) begin
            edge_cnt <= edge_cnt + {{(LW+1){1'b0}}, ev};
            smp_cnt  <= smp_nxt;
            rx_q     <= rx_nxt;
            if (out_ev && (smp_nxt < len_full)) begin
               tx_q  <= tx_sh;
               sdo_q <= lsb_q ? tx_sh[0] : tx_sh[lenm1_q];
            end
            if (fin) begin
               irq_q    <= 1'b1;
               rxd_q    <= rx_al;
               rx_q     <= '0;
               smp_cnt  <= '0;
               edge_cnt <= '0;
               if (pend_q) begin
                  pend_q <= 1'b0;
                  tx_q   <= pend_d;
                  sdo_q  <= first_bit(pend_d, lsb_q, lenm1_q);
               end else begin
                  busy_q <= 1'b0;
               end
            end
         end
      end
   end

   assign busy       = busy_q;
   assign master_run = busy_q & mst_q;
   assign rx_data    = rxd_q;
   assign done_irq   = irq_q;
   assign sdo        = sdo_q;
   assign sck_o      = sck_q;
endmodule

// File: rtl/sync_serial_port.sv
module sync_serial_port #(
   parameter int unsigned DW = 8,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned DIV_A = 2,
   parameter int unsigned DIV_B = 4,
   parameter int unsigned DIV_C = 16,
   parameter int unsigned DIV_D = 64,
   parameter int unsigned SDIV_A = 2,
   parameter int unsigned SDIV_B = 4,
   localparam int unsigned LW = $clog2(DW)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cfg_master,
   input  logic          cfg_two_wire,
   input  logic          cfg_lsb_first,
   input  logic          cfg_out_rise,
   input  logic          cfg_smp_rise,
   input  logic [LW-1:0] cfg_len_m1,
   input  logic [2:0]    cfg_src,
   input  logic          sys_tick,
   input  logic          tmr_tick,
   input  logic          ext_tick,
   input  logic          data_we,
   input  logic [DW-1:0] data_in,
   input  logic          start,
   input  logic          queue_we,
   input  logic [DW-1:0] queue_data,
   output logic          busy,
   output logic [DW-1:0] rx_data,
   output logic          done_irq,
   output logic          sdo,
   input  logic          sdi,
   output logic          sck_o,
   output logic          sck_oe,
   input  logic          sck_i
);
   generate
      if (DW < 2 || (1 << LW) != DW) $error("sync_serial_port: DW must be a power of two, at least 2");
   endgenerate

   logic half_tick, s_rise, s_fall, sdi_s, master_run;

   ssp_clkgen #(
      .DIV_A(DIV_A), .DIV_B(DIV_B), .DIV_C(DIV_C), .DIV_D(DIV_D),
      .SDIV_A(SDIV_A), .SDIV_B(SDIV_B)
   ) u_clkgen (
      .clk(clk), .rst_n(rst_n), .run(master_run), .src(cfg_src),
      .sys_tick(sys_tick), .tmr_tick(tmr_tick), .ext_tick(ext_tick),
      .half_tick(half_tick)
   );

   ssp_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .sck_i(sck_i), .sdi(sdi),
      .rise(s_rise), .fall(s_fall), .sdi_s(sdi_s)
   );

   ssp_shifter #(.DW(DW)) u_shift (
      .clk(clk), .rst_n(rst_n),
      .cfg_master(cfg_master), .cfg_two_wire(cfg_two_wire),
      .cfg_lsb_first(cfg_lsb_first), .cfg_out_rise(cfg_out_rise),
      .cfg_smp_rise(cfg_smp_rise), .cfg_len_m1(cfg_len_m1),
      .data_we(data_we), .data_in(data_in), .start(start),
      .queue_we(queue_we), .queue_data(queue_data),
      .half_tick(half_tick), .s_rise(s_rise), .s_fall(s_fall),
      .sdi_m(sdi), .sdi_s(sdi_s),
      .busy(busy), .master_run(master_run), .rx_data(rx_data),
      .done_irq(done_irq), .sdo(sdo), .sck_o(sck_o)
   );

   assign sck_oe = cfg_master;
endmodule

// File: rtl/ssp_chk.sv
module ssp_chk (
   input logic clk,
   input logic rst_n,
   input logic cfg_master,
   input logic cfg_out_rise,
   input logic busy,
   input logic done_irq,
   input logic sdo,
   input logic sck_o
);
   // R6
   irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_irq |=> !done_irq);

   // R6
   busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done_irq);

   // R3
   idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && $past(!busy) && cfg_master && $past(cfg_master)) |-> (sck_o == $past(cfg_out_rise)));

   // R10
   sdo_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && $past(!busy)) |-> $stable(sdo));
endmodule

bind sync_serial_port ssp_chk u_ssp_chk (
   .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master), .cfg_out_rise(cfg_out_rise),
   .busy(busy), .done_irq(done_irq), .sdo(sdo), .sck_o(sck_o)
);

// File: tb/tb_sync_serial_port.sv
module tb_sync_serial_port;
   logic clk = 1'b0, rst_n = 1'b0;
   logic cfg_master = 1'b1, cfg_two_wire = 1'b0, cfg_lsb_first = 1'b0;
   logic cfg_out_rise = 1'b0, cfg_smp_rise = 1'b1;
   logic [2:0] cfg_len_m1 = 3'd7, cfg_src = 3'd0;
   logic sys_tick = 1'b0, tmr_tick = 1'b0, ext_tick = 1'b0;
   logic data_we = 1'b0, start = 1'b0, queue_we = 1'b0;
   logic [7:0] data_in = 8'h00, queue_data = 8'h00;
   logic busy, done_irq, sdo, sck_o, sck_oe;
   logic [7:0] rx_data;
   logic slave_mode = 1'b0, tb_sdi = 1'b0, force_one = 1'b0, sck_i = 1'b0;
   wire  sdi = force_one ? 1'b1 : (slave_mode ? tb_sdi : sdo);

   int tests = 0, fails = 0;

   always #4 clk = ~clk;

   sync_serial_port dut (
      .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master), .cfg_two_wire(cfg_two_wire),
      .cfg_lsb_first(cfg_lsb_first), .cfg_out_rise(cfg_out_rise), .cfg_smp_rise(cfg_smp_rise),
      .cfg_len_m1(cfg_len_m1), .cfg_src(cfg_src), .sys_tick(sys_tick), .tmr_tick(tmr_tick),
      .ext_tick(ext_tick), .data_we(data_we), .data_in(data_in), .start(start),
      .queue_we(queue_we), .queue_data(queue_data), .busy(busy), .rx_data(rx_data),
      .done_irq(done_irq), .sdo(sdo), .sdi(sdi), .sck_o(sck_o), .sck_oe(sck_oe), .sck_i(sck_i)
   );

   // monitor state
   logic prev_sck = 1'b0, prev_sdo = 1'b0, prev_busy = 1'b0;
   logic caps [0:31];
   int ncap = 0, ntog = 0, nirq = 0, gap = 0, maxgap = 0, cyc = 0;
   int tog_t [0:3];

   always @(negedge clk) begin
      cyc <= cyc + 1;
      if (done_irq) nirq <= nirq + 1;
      if (busy && (sck_o == prev_sck)) gap <= gap + 1;
      else gap <= 0;
      if (busy && (gap + 1 > maxgap) && (sck_o == prev_sck)) maxgap <= gap + 1;
      if (cfg_master && (sck_o != prev_sck) && (prev_busy || busy)) begin
         if (ntog < 4) tog_t[ntog] <= cyc;
         ntog <= ntog + 1;
         if (sck_o == cfg_smp_rise && ncap < 32) begin
            caps[ncap] <= prev_sdo;
            ncap <= ncap + 1;
         end
      end
      prev_sck  <= sck_o;
      prev_sdo  <= sdo;
      prev_busy <= busy;
   end

   initial begin
      forever begin
         repeat (2) @(negedge clk);
         sys_tick = 1'b1;
         @(negedge clk);
         sys_tick = 1'b0;
      end
   end

   initial begin
      forever begin
         repeat (4) @(negedge clk);
         tmr_tick = 1'b1;
         @(negedge clk);
         tmr_tick = 1'b0;
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic finish_run;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   endtask

   task automatic clear_mon;
      @(negedge clk);
      ncap = 0; ntog = 0; nirq = 0; maxgap = 0;
   endtask

   task automatic write_and_start(input logic [7:0] d);
      @(negedge clk); data_we = 1'b1; data_in = d;
      @(negedge clk); data_we = 1'b0; start = 1'b1;
      @(negedge clk); start = 1'b0;
   endtask

   task automatic wait_idle;
      int n = 0;
      while ((busy || start) && n < 5000) begin @(negedge clk); n++; end
      @(negedge clk);
   endtask

   function automatic logic [7:0] mask_of(input int len);
      return 8'((16'h1 << len) - 1);
   endfunction

   function automatic logic exp_bit(input logic [7:0] d, input int len, input logic lsb, input int k);
      return lsb ? d[k] : d[len-1-k];
   endfunction

   task automatic master_frame(input int len, input logic lsb, input logic oe,
                               input logic se, input logic [7:0] d);
      int bad;
      @(negedge clk);
      cfg_master = 1'b1; cfg_len_m1 = 3'(len - 1); cfg_lsb_first = lsb;
      cfg_out_rise = oe; cfg_smp_rise = se; cfg_src = 3'd0;
      clear_mon();
      write_and_start(d);
      wait_idle();
      check(rx_data == (d & mask_of(len)), "R1/R3 loopback", rx_data, d & mask_of(len));
      bad = 0;
      for (int k = 0; k < len; k++) if (caps[k] !== exp_bit(d, len, lsb, k)) bad++;
      check(bad == 0 && ncap == len, "R2 bit order", ncap, len);
      check(ntog == 2 * len && sck_o == oe, "R3 edge count/idle", ntog, 2 * len);
      check(nirq == 1, "R6 one irq per frame", nirq, 1);
   endtask

   task automatic slave_frame(input int len, input logic lsb, input logic [7:0] d,
                              input logic [7:0] pat);
      logic [7:0] exp_rx;
      int bad;
      @(negedge clk);
      cfg_master = 1'b0; slave_mode = 1'b1; cfg_len_m1 = 3'(len - 1); cfg_lsb_first = lsb;
      cfg_out_rise = 1'b0; cfg_smp_rise = 1'b1; sck_i = 1'b0;
      clear_mon();
      write_and_start(d);
      exp_rx = 8'h00; bad = 0;
      for (int k = 0; k < len; k++) begin
         tb_sdi = pat[k];
         if (lsb) exp_rx[k] = pat[k]; else exp_rx[len-1-k] = pat[k];
         repeat (8) @(negedge clk);
         if (sdo !== exp_bit(d, len, lsb, k)) bad++;
         sck_i = 1'b1;
         repeat (8) @(negedge clk);
         sck_i = 1'b0;
      end
      repeat (6) @(negedge clk);
      check(!busy && nirq == 1, "R9 slave completes", nirq, 1);
      check(rx_data == exp_rx, "R9/R2 slave rx", rx_data, exp_rx);
      check(bad == 0, "R9/R2 slave sdo order", bad, 0);
      check(sck_oe == 1'b0, "R9 slave oe low", sck_oe, 0);
      slave_mode = 1'b0;
   endtask

   task automatic measure_half(input logic [2:0] src, input int exp);
      @(negedge clk);
      cfg_master = 1'b1; cfg_src = src; cfg_len_m1 = 3'd7; cfg_out_rise = 1'b0;
      cfg_smp_rise = 1'b1; cfg_lsb_first = 1'b0;
      clear_mon();
      write_and_start(8'h5A);
      wait_idle();
      check(tog_t[2] - tog_t[1] == exp && tog_t[3] - tog_t[2] == exp,
            $sformatf("R5 src %0d half period", src), tog_t[2] - tog_t[1], exp);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      logic sdo_hold;
      repeat (3) @(negedge clk);
      check(busy == 1'b0 && done_irq == 1'b0 && rx_data == 8'h00, "reset state", busy, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R1 R2 R3: full sweep over length, order and edge pairing
      for (int len = 1; len <= 8; len++)
         for (int cfg = 0; cfg < 8; cfg++)
            master_frame(len, cfg[0], cfg[1], cfg[2], 8'((len * 8'h3B) ^ (cfg * 8'h57)));

      // R5: clock sources
      measure_half(3'd0, 1);
      measure_half(3'd1, 2);
      measure_half(3'd2, 8);
      measure_half(3'd3, 32);
      measure_half(3'd4, 3);
      measure_half(3'd5, 6);
      measure_half(3'd6, 5);

      // R4: two-wire ignores sdi
      @(negedge clk);
      cfg_src = 3'd0; cfg_two_wire = 1'b1; force_one = 1'b1;
      write_and_start(8'hC3);
      wait_idle();
      check(rx_data == 8'h00, "R4 two-wire rx zero", rx_data, 0);
      cfg_two_wire = 1'b0; force_one = 1'b0;

      // R7: writes and start while busy are ignored
      @(negedge clk);
      cfg_src = 3'd2; cfg_len_m1 = 3'd7; cfg_lsb_first = 1'b0;
      clear_mon();
      write_and_start(8'hA5);
      check(busy == 1'b1, "R7 busy after start", busy, 1);
      data_we = 1'b1; data_in = 8'h3C; start = 1'b1;
      @(negedge clk);
      data_we = 1'b0; start = 1'b0;
      wait_idle();
      check(nirq == 1, "R7 start while busy ignored", nirq, 1);
      sdo_hold = sdo;
      clear_mon();
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
      wait_idle();
      check(rx_data == 8'hA5, "R7 write while busy ignored", rx_data, 8'hA5);

      // R10: sdo holds while idle
      sdo_hold = sdo;
      repeat (10) @(negedge clk);
      check(sdo == sdo_hold, "R10 sdo idle hold", sdo, sdo_hold);

      // R8: queued frame runs with no gap
      @(negedge clk);
      cfg_src = 3'd1; cfg_len_m1 = 3'd4; cfg_lsb_first = 1'b1;
      cfg_out_rise = 1'b1; cfg_smp_rise = 1'b0;
      clear_mon();
      write_and_start(8'h13);
      queue_we = 1'b1; queue_data = 8'h0E;
      @(negedge clk);
      queue_we = 1'b0;
      while (nirq == 0) @(negedge clk);
      check(busy == 1'b1, "R8 busy held across boundary", busy, 1);
      check(rx_data == 8'h13, "R8 first frame rx", rx_data, 8'h13);
      wait_idle();
      check(nirq == 2, "R8 two completions", nirq, 2);
      check(rx_data == 8'h0E, "R8 queued frame rx", rx_data, 8'h0E);
      check(maxgap <= 2 && ntog == 20, "R8 no idle gap", maxgap, 2);

      // R9: slave sweep
      for (int len = 1; len <= 8; len++)
         for (int lsb = 0; lsb < 2; lsb++)
            slave_frame(len, lsb[0], 8'(8'h96 ^ (len * 8'h11)), 8'(8'h6D + len * 8'h07 + lsb));

      finish_run();
   end
endmodule